// File: doc/BRIEF.md
# Object Attribute Block Copy Engine

This engine copies a fixed run of bytes from any page-aligned region of the system address space into object attribute memory. It is started when the CPU writes to one I/O address. The written byte names the source page. The copy source starts at offset zero inside that page, and the destination starts at a fixed base address. Both addresses advance by one for every byte.

During a copy the engine is a bus master. Each byte takes two bus cycles: a read of the source, then a write of that byte to the destination. The read goes through the normal system decode, so any readable target can serve as the source. The engine raises a request output and a busy flag for the whole copy. Arbitration against the CPU belongs to the surrounding fabric.

A parameter selects the read timing of the targets. With a synchronous target, the read data returns in the cycle after the read strobe and passes straight to the write. With a combinational target, the engine captures the data at the end of the read cycle.

Top module: `oamdma_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `bus_req`, `bus_rd` and `bus_wr` are all 0 and `bus_addr` is 0.
- R2: A CPU write (`cpu_wr`=1) to address 0xFF46 starts a copy. In the following cycle `bus_rd` is 1 and `bus_addr` equals {written byte, 8'h00}. A CPU write to any other address, or address 0xFF46 presented with `cpu_wr`=0, starts nothing.
- R3: During a copy, bus cycles alternate: each read cycle is followed by one write cycle. `bus_rd` and `bus_wr` are never 1 together.
- R4: Byte n (n = 0..159) is read from {source page, n}, in ascending order of n.
- R5: Byte n is written to 0xFE00 + n. The value written is the byte the source returned for that read.
- R6: Exactly 160 bytes are copied. `busy` stays high for 320 cycles, then the engine returns to idle.
- R7: A trigger write during a copy abandons it. The next cycle reads byte 0 of the new page, and 160 further bytes are then copied.
- R8: `bus_req` equals `busy` in every cycle. Both are 1 exactly while a copy is running.
- R9: With synchronous targets (default), `bus_wdata` in a write cycle equals `bus_rdata` of that cycle. The target returns read data in the cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe on the I/O snoop path |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data; on a trigger, the source page |
| bus_req | output | 1 | Bus ownership request |
| busy | output | 1 | Copy in progress |
| bus_rd | output | 1 | Read strobe on the system bus |
| bus_wr | output | 1 | Write strobe on the system bus |
| bus_addr | output | 16 | Bus address driven by the engine |
| bus_wdata | output | 8 | Bus write data |
| bus_rdata | input | 8 | Bus read data from the addressed target |

## Verification
The hardest case to reach is a restart that lands in the middle of a copy. The new trigger can arrive in either a read cycle or a write cycle. When it lands on a write cycle, the abandoned write still goes out with the old page's data. The bench tracks this with a per-cycle bus monitor. The monitor checks each read and write against the page and byte index it expects. It resets that index only after it has checked the cycle in which the trigger write is seen. Directed restarts are placed at an even and at an odd cycle offset, so one falls on each cycle type.

// File: rtl/oamdma_pkg.sv
package oamdma_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2
   } dma_state_e;
endpackage

// File: rtl/oamdma_trigger.sv
module oamdma_trigger #(
   parameter int          ADDR_W    = 16,
   parameter logic [15:0] TRIG_ADDR = 16'hFF46
) (
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              start
);
   // Snoop of the CPU write path: one compare, no state.
   always_comb start = cpu_wr && (cpu_addr == TRIG_ADDR[ADDR_W-1:0]);
endmodule

// File: rtl/oamdma_fsm.sv
module oamdma_fsm
   import oamdma_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       last,
   output dma_state_e state,
   output logic       advance
);
   dma_state_e state_nx;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:  state_nx = ST_IDLE;
         ST_READ:  state_nx = ST_WRITE;
         ST_WRITE: state_nx = last ? ST_IDLE : ST_READ;
         default:  state_nx = ST_IDLE;
      endcase
      // A trigger has priority over normal progress and restarts the copy.
      if (start) state_nx = ST_READ;
   end

   // The index moves on only after a completed write that is not preempted.
   always_comb advance = (state == ST_WRITE) && !start && !last;

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end
endmodule

// File: rtl/oamdma_addr_gen.sv
module oamdma_addr_gen #(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int XFER_LEN = 160,
   localparam int LO_W    = ADDR_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] page_in,
   input  logic              advance,
   output logic [DATA_W-1:0] page,
   output logic [LO_W-1:0]   idx,
   output logic              last
);
   localparam logic [LO_W-1:0] LAST_IDX = LO_W'(XFER_LEN - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page <= '0;
         idx  <= '0;
      end else if (start) begin
         page <= page_in;
         idx  <= '0;
      end else if (advance) begin
         idx  <= idx + 1'b1;
      end
   end

   always_comb last = (idx == LAST_IDX);
endmodule

// File: rtl/oamdma_engine.sv
module oamdma_engine
   import oamdma_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 8,
   parameter int          XFER_LEN  = 160,
   parameter logic [15:0] DST_BASE  = 16'hFE00,
   parameter logic [15:0] TRIG_ADDR = 16'hFF46,
   parameter bit          SYNC_READ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              bus_req,
   output logic              busy,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata
);
   localparam int LO_W = ADDR_W - DATA_W;

   if (LO_W < 1) begin : g_bad_width
      $error("ADDR_W must exceed DATA_W");
   end
   if (XFER_LEN < 1 || XFER_LEN > (1 << LO_W)) begin : g_bad_len
      $error("XFER_LEN must fit inside one source page");
   end
   if (ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W is limited to 16 by the address parameters");
   end

   dma_state_e              state;
   logic                    start, advance, last;
   logic [DATA_W-1:0]       page;
   logic [LO_W-1:0]         idx;

   oamdma_trigger #(.ADDR_W(ADDR_W), .TRIG_ADDR(TRIG_ADDR)) u_trig (
      .cpu_wr   (cpu_wr),
      .cpu_addr (cpu_addr),
      .start    (start)
   );

   oamdma_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .last    (last),
      .state   (state),
      .advance (advance)
   );

   oamdma_addr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .XFER_LEN(XFER_LEN)) u_agen (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .page_in (cpu_wdata),
      .advance (advance),
      .page    (page),
      .idx     (idx),
      .last    (last)
   );

   always_comb begin
      busy    = (state != ST_IDLE);
      bus_req = busy;
      bus_rd  = (state == ST_READ);
      bus_wr  = (state == ST_WRITE);
      unique case (state)
         ST_READ:  bus_addr = {page, idx};
         ST_WRITE: bus_addr = DST_BASE[ADDR_W-1:0] + ADDR_W'(idx);
         default:  bus_addr = '0;
      endcase
   end

   if (SYNC_READ) begin : g_sync_rd
      // The target answers one cycle after the strobe, i.e. in the write cycle.
      always_comb bus_wdata = bus_wr ? bus_rdata : '0;
   end else begin : g_comb_rd
      logic [DATA_W-1:0] hold_q;
      always_ff @(posedge clk) begin
         if (!rst_n)      hold_q <= '0;
         else if (bus_rd) hold_q <= bus_rdata;
      end
      always_comb bus_wdata = bus_wr ? hold_q : '0;
   end
endmodule

// File: rtl/oamdma_engine_chk.sv
module oamdma_engine_chk #(
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 8,
   parameter int          XFER_LEN  = 160,
   parameter logic [15:0] DST_BASE  = 16'hFE00,
   parameter logic [15:0] TRIG_ADDR = 16'hFF46,
   parameter bit          SYNC_READ = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_wr,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [DATA_W-1:0] cpu_wdata,
   input logic              bus_req,
   input logic              busy,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata
);
   localparam int LO_W = ADDR_W - DATA_W;
   logic          trig;
   logic [15:0]   wr_cnt;
   logic [LO_W-1:0] wr_off;

   always_comb trig   = cpu_wr && (cpu_addr == TRIG_ADDR[ADDR_W-1:0]);
   always_comb wr_off = LO_W'(bus_addr - DST_BASE[ADDR_W-1:0]);

   always_ff @(posedge clk) begin
      if (!rst_n)      wr_cnt <= '0;
      else if (trig)   wr_cnt <= '0;
      else if (bus_wr) wr_cnt <= wr_cnt + 16'd1;
   end

   a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));

   a_r3_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && !trig |=> bus_wr);

   a_r8_req_is_busy: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req == busy);

   a_r2_start_read: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> bus_rd && bus_addr == {$past(cpu_wdata), {LO_W{1'b0}}});

   a_r2_no_spurious_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(trig));

   a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && !trig && busy |=> !bus_rd || bus_addr[LO_W-1:0] == $past(wr_off) + 1'b1);

   a_r6_full_count: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> wr_cnt == 16'(XFER_LEN));

   a_r9_pass_data: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && SYNC_READ |-> bus_wdata == bus_rdata);
endmodule

bind oamdma_engine oamdma_engine_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .XFER_LEN(XFER_LEN),
   .DST_BASE(DST_BASE), .TRIG_ADDR(TRIG_ADDR), .SYNC_READ(SYNC_READ)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
   .cpu_wdata(cpu_wdata), .bus_req(bus_req), .busy(busy), .bus_rd(bus_rd),
   .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata)
);

// File: tb/oamdma_engine_tb_top.sv
module oamdma_engine_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NBYTES     = 160;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        bus_req, busy, bus_rd, bus_wr;
   logic [15:0] bus_addr;
   logic [7:0]  bus_wdata;
   logic [7:0]  bus_rdata = '0;

   int checks = 0;
   int errors = 0;

   // Monitor state
   logic [7:0] exp_page = '0;
   int         rd_idx = 0;
   int         wr_idx = 0;
   int         rd_seen = 0;
   int         wr_seen = 0;
   int         mon_errs = 0;
   logic [7:0] oam [NBYTES];

   always #(CLK_PERIOD/2) clk = ~clk;

   oamdma_engine dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .bus_req(bus_req), .busy(busy), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata)
   );

   function automatic logic [7:0] src_val(input logic [15:0] a);
      return a[7:0] ^ {a[14:8], a[15]} ^ 8'h5A;
   endfunction

   // Synchronous bus target model: source pattern plus destination memory.
   always @(posedge clk) begin
      if (bus_rd) bus_rdata <= src_val(bus_addr);
      if (bus_wr && bus_addr >= 16'hFE00 && bus_addr < 16'hFE00 + NBYTES)
         oam[bus_addr - 16'hFE00] <= bus_wdata;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // Cycle monitor (R3, R4, R5, R9); indices restart after the trigger cycle is checked.
   always @(negedge clk) begin
      if (rst_n) begin
         if (bus_rd && bus_wr) mon_errs++;
         if (bus_rd) begin
            rd_seen++;
            if (bus_addr != {exp_page, 8'(rd_idx)}) begin
               mon_errs++;
               $display("FAIL R4 read addr actual=0x%0h expected=0x%0h",
                        bus_addr, {exp_page, 8'(rd_idx)});
            end
            rd_idx++;
         end
         if (bus_wr) begin
            wr_seen++;
            if (bus_addr != 16'hFE00 + 16'(wr_idx) ||
                bus_wdata != src_val({exp_page, 8'(wr_idx)})) begin
               mon_errs++;
               $display("FAIL R5 write addr/data actual=0x%0h/0x%0h expected=0x%0h/0x%0h",
                        bus_addr, bus_wdata, 16'hFE00 + 16'(wr_idx),
                        src_val({exp_page, 8'(wr_idx)}));
            end
            wr_idx++;
         end
         if (cpu_wr && cpu_addr == 16'hFF46) begin
            exp_page = cpu_wdata;
            rd_idx = 0;
            wr_idx = 0;
         end
      end
   end

   task automatic cpu_write(input logic [15:0] a, input logic [7:0] d, input bit wr);
      @(posedge clk); #1;
      cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
      @(posedge clk); #1;
      cpu_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0;
   endtask

   task automatic wait_idle(output int cyc);
      cyc = 0;
      while (busy && cyc < 2000) begin
         cyc++;
         @(posedge clk); #1;
      end
   endtask

   task automatic check_oam(input logic [7:0] pg, input string req);
      int bad = 0;
      for (int i = 0; i < NBYTES; i++)
         if (oam[i] !== src_val({pg, 8'(i)})) bad++;
      check(bad == 0, req, "destination bytes mismatching", bad, 0);
   endtask

   task automatic t_reset;
      #1;
      check(!busy && !bus_req && !bus_rd && !bus_wr && bus_addr == 0, "R1",
            "idle outputs after reset", {busy, bus_req, bus_rd, bus_wr}, 0);
   endtask

   task automatic t_copy(input logic [7:0] pg);
      int cyc;
      int me = mon_errs;
      for (int i = 0; i < NBYTES; i++) oam[i] = 8'hxx;
      rd_seen = 0; wr_seen = 0;
      @(posedge clk); #1;
      cpu_wr = 1'b1; cpu_addr = 16'hFF46; cpu_wdata = pg;
      @(posedge clk); #1;
      cpu_wr = 1'b0; cpu_addr = '0;
      check(bus_rd && bus_addr == {pg, 8'h00}, "R2", "first read address",
            bus_addr, {pg, 8'h00});
      check(bus_req == busy && busy, "R8", "request mirrors busy", bus_req, 1);
      wait_idle(cyc);
      check(cyc == 2 * NBYTES, "R6", "busy cycles", cyc, 2 * NBYTES);
      check(rd_seen == NBYTES && wr_seen == NBYTES, "R3", "read/write counts",
            wr_seen, NBYTES);
      check(!bus_req && !bus_rd && !bus_wr, "R8", "idle after copy", bus_req, 0);
      check(mon_errs == me, "R4", "monitor ordering errors", mon_errs - me, 0);
      check_oam(pg, "R5");
   endtask

   task automatic t_ignore;
      int rs = rd_seen;
      cpu_write(16'hFF47, 8'h12, 1'b1);
      cpu_write(16'hFF46, 8'h34, 1'b0);
      repeat (4) @(posedge clk);
      #1;
      check(!busy && rd_seen == rs, "R2", "no start on non-trigger writes",
            rd_seen - rs, 0);
   endtask

   task automatic t_restart(input logic [7:0] pa, input logic [7:0] pb, input int gap);
      int cyc;
      int me;
      for (int i = 0; i < NBYTES; i++) oam[i] = 8'hxx;
      cpu_write(16'hFF46, pa, 1'b1);
      repeat (gap) @(posedge clk);
      #1;
      me = mon_errs;
      rd_seen = 0; wr_seen = 0;
      cpu_wr = 1'b1; cpu_addr = 16'hFF46; cpu_wdata = pb;
      @(posedge clk); #1;
      cpu_wr = 1'b0; cpu_addr = '0;
      check(bus_rd && bus_addr == {pb, 8'h00}, "R7", "restart read address",
            bus_addr, {pb, 8'h00});
      wait_idle(cyc);
      check(cyc == 2 * NBYTES, "R7", "busy cycles after restart", cyc, 2 * NBYTES);
      check(mon_errs == me, "R7", "monitor errors across restart", mon_errs - me, 0);
      check_oam(pb, "R7");
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      @(posedge clk); #1;
      rst_n = 1'b1;
      t_reset();
      t_copy(8'hC1);
      t_copy(8'h00);
      t_copy(8'hFF);
      t_ignore();
      t_restart(8'h40, 8'h82, 51);
      t_restart(8'h13, 8'h9A, 100);
      check(mon_errs == 0, "R9", "total monitor errors", mon_errs, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule